// File: doc/BRIEF.md
# Dual-Format Serial Transmitter with Output Tristate

This block is the transmit half of a synchronous serial port run as a clock master. It makes its own serial clock from the system clock and shifts a parallel word out most significant bit first. The word can be 4 to 32 bits long. Two frame formats are offered. In the SPI format the frame strobe is active low. In the Microwire format the strobe is active high. A tristate control can let the data pin float between frames, and the moment the driver lets go depends on the format. In the SPI format, an end-of-data value is driven on the pin in the half clock that follows the last falling edge.

A one-cycle `start` pulse captures the data word, the length, the format, the tristate control and the end-of-data value. The block then keeps `busy` high until the frame is over. While `busy` is high, changes on these inputs and further `start` pulses have no effect.

Behaviour is built around six states:
- `ST_IDLE`: no frame in progress.
- `ST_LEAD`: the frame strobe is asserted and the MSB is presented, with the clock low.
- `ST_HIGH`: clock high. A receiver samples on the rising edge into this state.
- `ST_LOW`: clock low. The falling edge into this state moves to the next bit.
- `ST_TAIL`: SPI only. The end-of-data value is driven with the clock low.
- `ST_FINAL`: Microwire only. The clock is low before the strobe drops.

The state transitions are:
- Idle to lead, on `start`.
- Lead to high.
- High to low, when the bit is not the last one.
- Low to high.
- High to tail (SPI) or high to final (Microwire), after the LSB.
- Tail or final back to idle.

Each state except idle lasts `HALF` system cycles.

Top module: `ser_tx`

## Requirements
- R1: The frame length is `len_m1`+1 bits. Values of `len_m1` below 3 are treated as 3, so the shortest frame is 4 bits. The bits `tx_data[N-1:0]` are sent MSB first on `sdo`.
- R2: When the captured tristate control is 0, `sdo_oe` is 1 in every cycle, in both formats and between frames.
- R3: In SPI format (`fmt`=0) with tristate enabled, `sdo_oe` is 1 exactly while `frm` is low. `frm` is low from the start of the frame to its end, and high when idle.
- R4: In SPI format, after the falling clock edge that ends the LSB, `sdo` carries the captured `eod_val` for one half period while `frm` is still low. Outside a frame, `sdo` is 0.
- R5: In Microwire format (`fmt`=1) with tristate enabled, `sdo_oe` rises in the same cycle that `sdo` first presents the MSB, which is the first cycle of the frame. `frm` is high during a Microwire frame and low when idle.
- R6: In Microwire format with tristate enabled, `sdo_oe` falls at the rising `sclk` edge that samples the LSB. It never falls in a cycle without a rising `sclk` edge while a frame is active.
- R7: `sclk` is low outside a frame. Each clock phase lasts `HALF` system cycles. The frame opens with one low phase. During a frame, `sdo` changes only at a falling `sclk` edge.
- R8: After `start`, `busy` stays high for (2N+1)·`HALF` cycles. Starts and changes to configuration or data while busy have no effect on the frame in progress or on the idle levels that follow it.
- R9: After reset, `sclk`=0, `frm`=1, `sdo`=0, `sdo_oe`=1 and `busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a frame |
| tx_data | input | MAXW | Word to send, right-aligned |
| len_m1 | input | $clog2(MAXW) | Frame length minus one |
| fmt | input | 1 | 0 = SPI frame, 1 = Microwire frame |
| tri_en | input | 1 | 1 = float `sdo` between frames |
| eod_val | input | 1 | Value driven after the last SPI falling edge |
| sclk | output | 1 | Serial clock, idles low |
| frm | output | 1 | Frame strobe (polarity depends on the format) |
| sdo | output | 1 | Serial data |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| busy | output | 1 | High while a frame is in progress |

## Verification
Two events can fall in the same cycle. In Microwire format with tristate enabled, the driver release and the rising clock edge that samples the LSB happen together. In SPI format, the last falling edge happens together with the switch of `sdo` to the end-of-data value. The bench sweeps both formats, both tristate settings, both end-of-data values and several lengths, including 4 and 32. At each half-cycle it compares `sclk`, `sdo`, `sdo_oe` and `frm` against a phase model computed from the cycle index, so an output enable that drops one cycle early or late is reported at that exact cycle. Mid-frame starts and configuration flips are injected during every frame, and the idle levels that follow show whether they leaked in.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL,
        ST_FINAL
    } tx_state_e;

    typedef enum logic {
        FMT_SPI   = 1'b0,
        FMT_MWIRE = 1'b1
    } fmt_e;

endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
    parameter int MAXW = 32,
    localparam int LW = $clog2(MAXW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            shift,
    input  logic [MAXW-1:0] data,
    input  logic [LW-1:0]   len_m1,
    output logic            msb
);
    logic [MAXW-1:0] sh;

    // left-align the active bits so the MSB of the frame sits at the top
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (load) begin
            sh <= data << (LW'(MAXW - 1) - len_m1);
        end else if (shift) begin
            sh <= {sh[MAXW-2:0], 1'b0};
        end
    end

    assign msb = sh[MAXW-1];
endmodule

// File: rtl/tx_pin_mux.sv
module tx_pin_mux
    import ser_tx_pkg::*;
(
    input  tx_state_e state,
    input  fmt_e      fmt_q,
    input  logic      tri_q,
    input  logic      eod_q,
    input  logic      last,
    input  logic      msb,
    output logic      sclk,
    output logic      frm,
    output logic      sdo,
    output logic      sdo_oe
);
    logic active;

    always_comb begin
        active = (state != ST_IDLE);
        sclk   = (state == ST_HIGH);
        frm    = (fmt_q == FMT_SPI) ? !active : active;

        unique case (state)
            ST_LEAD, ST_HIGH, ST_LOW: sdo = msb;
            ST_TAIL:                  sdo = eod_q;
            default:                  sdo = 1'b0;
        endcase

        if (!tri_q) begin
            sdo_oe = 1'b1;
        end else if (fmt_q == FMT_SPI) begin
            sdo_oe = active;
        end else begin
            // release on the rising edge that samples the LSB
            sdo_oe = (state == ST_LEAD) || (state == ST_LOW) ||
                     ((state == ST_HIGH) && !last);
        end
    end
endmodule

// File: rtl/ser_tx.sv
module ser_tx
    import ser_tx_pkg::*;
#(
    parameter int MAXW = 32,
    parameter int HALF = 2,
    localparam int LW = $clog2(MAXW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [MAXW-1:0] tx_data,
    input  logic [LW-1:0]   len_m1,
    input  logic            fmt,
    input  logic            tri_en,
    input  logic            eod_val,
    output logic            sclk,
    output logic            frm,
    output logic            sdo,
    output logic            sdo_oe,
    output logic            busy
);
    localparam logic [LW-1:0] MIN_M1 = LW'(3);

    tx_state_e     state, nxt;
    fmt_e          fmt_q;
    logic          tri_q, eod_q;
    logic [LW-1:0] bits_left;
    logic [LW-1:0] len_eff;
    logic          tick, load, shift, last, msb;

    assign len_eff = (len_m1 < MIN_M1) ? MIN_M1 : len_m1;
    assign load    = (state == ST_IDLE) && start;
    assign last    = (bits_left == '0);
    assign shift   = (state == ST_HIGH) && tick && !last;
    assign busy    = (state != ST_IDLE);

    phase_timer #(.HALF(HALF)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    tx_shifter #(.MAXW(MAXW)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .shift  (shift),
        .data   (tx_data),
        .len_m1 (len_eff),
        .msb    (msb)
    );

    tx_pin_mux u_mux (
        .state  (state),
        .fmt_q  (fmt_q),
        .tri_q  (tri_q),
        .eod_q  (eod_q),
        .last   (last),
        .msb    (msb),
        .sclk   (sclk),
        .frm    (frm),
        .sdo    (sdo),
        .sdo_oe (sdo_oe)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_LEAD;
            ST_LEAD:  if (tick)  nxt = ST_HIGH;
            ST_HIGH:  if (tick) begin
                          if (!last)                nxt = ST_LOW;
                          else if (fmt_q == FMT_SPI) nxt = ST_TAIL;
                          else                      nxt = ST_FINAL;
                      end
            ST_LOW:   if (tick)  nxt = ST_HIGH;
            ST_TAIL:  if (tick)  nxt = ST_IDLE;
            ST_FINAL: if (tick)  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // configuration capture and bit count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q     <= FMT_SPI;
            tri_q     <= 1'b0;
            eod_q     <= 1'b0;
            bits_left <= '0;
        end else if (load) begin
            fmt_q     <= fmt_e'(fmt);
            tri_q     <= tri_en;
            eod_q     <= eod_val;
            bits_left <= len_eff;
        end else if (shift) begin
            bits_left <= bits_left - 1'b1;
        end
    end
endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk
    import ser_tx_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic sclk,
    input logic frm,
    input logic sdo,
    input logic sdo_oe,
    input fmt_e fmt_q,
    input logic tri_q,
    input logic eod_q
);
    a_r2_always_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !tri_q |-> sdo_oe);

    a_r3_spi_oe_tracks_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_q == FMT_SPI && tri_q) |-> (sdo_oe == !frm));

    a_r6_release_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $fell(sdo_oe)) |-> $rose(sclk));

    a_r7_clock_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    a_r7_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$fell(sclk)) |-> $stable(sdo));

    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(fmt_q) && $stable(tri_q) && $stable(eod_q)));
endmodule

bind ser_tx ser_tx_chk u_chk (.*);

// File: tb/test_ser_tx.sv
module test_ser_tx;
    localparam int MAXW = 32;
    localparam int HALF = 2;
    localparam int LW   = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [MAXW-1:0] tx_data = '0;
    logic [LW-1:0]   len_m1 = '0;
    logic            fmt = 1'b0, tri_en = 1'b0, eod_val = 1'b0;
    logic            sclk, frm, sdo, sdo_oe, busy;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ser_tx #(.MAXW(MAXW), .HALF(HALF)) i_ser_tx (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_data(tx_data),
        .len_m1(len_m1), .fmt(fmt), .tri_en(tri_en), .eod_val(eod_val),
        .sclk(sclk), .frm(frm), .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy)
    );

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s t=%0t {sclk,frm,sdo,oe,busy} act=%b exp=%b", req, $time, act, exp);
        end
    endtask

    // one frame; requirement tags R1 R3 R4 R5 R6 R7 R8 checked by the phase model
    task automatic frame(input logic [31:0] d, input int lm1, input logic f,
                         input logic t, input logic e);
        int n;
        int ncyc;
        logic [4:0] ex;
        n    = (lm1 < 3) ? 4 : lm1 + 1;
        ncyc = (2 * n + 1) * HALF;
        @(negedge clk);
        tx_data = d; len_m1 = LW'(lm1); fmt = f; tri_en = t; eod_val = e; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R8: scramble all inputs while busy
        tx_data = ~d; len_m1 = LW'(31 - lm1); fmt = ~f; tri_en = ~t; eod_val = ~e;
        for (int j = 0; j < ncyc; j++) begin
            int p;
            int b;
            logic xs, xd, xo;
            p  = j / HALF;
            xs = p[0];
            if (p == 2 * n) begin
                xd = (f == 1'b0) ? e : 1'b0;
            end else begin
                b  = (p == 0) ? 0 : (p - 1 + (p % 2 == 0 ? 1 : 0)) / 2;
                xd = d[n - 1 - b];
            end
            if (!t)        xo = 1'b1;
            else if (!f)   xo = 1'b1;
            else           xo = (p < 2 * n - 1);
            ex = {xs, f ? 1'b1 : 1'b0, xd, xo, 1'b1};
            if (p == 2 * n)          chk(f ? "R6" : "R4", {sclk, frm, sdo, sdo_oe, busy}, ex);
            else if (p == 2 * n - 1) chk(f ? "R6" : "R3", {sclk, frm, sdo, sdo_oe, busy}, ex);
            else if (p == 0)         chk(f ? "R5" : "R1", {sclk, frm, sdo, sdo_oe, busy}, ex);
            else                     chk(t ? "R7" : "R2", {sclk, frm, sdo, sdo_oe, busy}, ex);
            start = (j == 3);
            @(negedge clk);
        end
        start = 1'b0;
        // idle levels after the frame: R8 end of busy and captured config
        ex = {1'b0, f ? 1'b0 : 1'b1, 1'b0, t ? 1'b0 : 1'b1, 1'b0};
        chk("R8", {sclk, frm, sdo, sdo_oe, busy}, ex);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int lens[6];
        lens = '{3, 4, 8, 15, 30, 31};
        repeat (3) @(negedge clk);
        chk("R9", {sclk, frm, sdo, sdo_oe, busy}, 5'b01010);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", {sclk, frm, sdo, sdo_oe, busy}, 5'b01010);
        for (int f = 0; f < 2; f++)
            for (int t = 0; t < 2; t++)
                for (int e = 0; e < 2; e++)
                    for (int k = 0; k < 6; k++)
                        frame(32'hA5C3_96E1 ^ (32'h0101_0101 * (k + 1)) ^ {31'd0, e[0]},
                              lens[k], f[0], t[0], e[0]);
        // R1 clamp: len_m1 below 3 gives a 4-bit frame
        frame(32'h0000_000B, 1, 1'b0, 1'b1, 1'b1);
        frame(32'h0000_0006, 0, 1'b1, 1'b1, 1'b0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule